// File: doc/BRIEF.md
# Four-Phase Handshake Relay Sequencer

This clocked controller bridges two four-phase handshake channels. An upstream master raises a request. The controller answers by running one complete request/acknowledge cycle on a downstream channel. Only after the downstream side has returned to zero does it acknowledge upstream. The downstream cycle is therefore fully nested inside the upstream request.

Both incoming handshake lines pass through a two-flop synchroniser before edge detection. Each step of the sequence waits for exactly one input edge. Any other edge is a protocol violation. A violation raises a sticky error flag and freezes the sequencer and its outputs until reset.

Top module: `hs_relay_seq`

## Requirements
- R1: After reset, `dn_req`, `up_ack` and `proto_err` are all low and the sequencer waits for an upstream request.
- R2: In the idle step, a rising `up_req` makes `dn_req` rise. The rise appears on the third rising clock edge after `up_req` changes: two synchroniser edges, then one register edge. It is still low after the second edge.
- R3: While `dn_req` is high, a rising `dn_ack` makes `dn_req` fall on the third clock edge after the change.
- R4: After `dn_req` has fallen, a falling `dn_ack` makes `up_ack` rise on the third clock edge after the change.
- R5: While `up_ack` is high, a falling `up_req` makes `up_ack` fall on the third clock edge. The sequencer returns to idle and accepts a new request.
- R6: `dn_req` and `up_ack` are never high in the same cycle.
- R7: A synchronised edge on `up_req` or `dn_ack` other than the one the current step expects sets `proto_err`. After that, `proto_err`, `dn_req` and `up_ack` keep their values until reset, whatever the inputs do.
- R8: When the expected edge and an unexpected edge reach the sequencer in the same cycle, the sequencer treats it as an error (R7) and does not advance. Both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream request (asynchronous) |
| up_ack | output | 1 | Acknowledge to upstream |
| dn_req | output | 1 | Request to downstream |
| dn_ack | input | 1 | Downstream acknowledge (asynchronous) |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
Progress and violation detection can fall in the same cycle. This happens when the awaited edge arrives together with a stray edge on the other line. The bench provokes it by toggling `up_req` and `dn_ack` on the same clock. Once while `dn_req` is high, it raises `dn_ack` and drops `up_req` together. It then checks that the error flag rises and that `dn_req` stays high rather than falling. A behavioural reference model tracks the synchroniser delay and the step, and its outputs are compared with the design's outputs on every clock.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DN_REQ = 2'd1,
    PH_DN_REL = 2'd2,
    PH_UP_ACK = 2'd3
  } phase_t;

  localparam int EV_W       = 4;
  localparam int EV_AR_RISE = 0;
  localparam int EV_AR_FALL = 1;
  localparam int EV_BA_RISE = 2;
  localparam int EV_BA_FALL = 3;

  // one-hot mask of the single edge each step waits for
  function automatic logic [EV_W-1:0] awaited_edge(phase_t p);
    logic [EV_W-1:0] m;
    m = '0;
    case (p)
      PH_IDLE:   m[EV_AR_RISE] = 1'b1;
      PH_DN_REQ: m[EV_BA_RISE] = 1'b1;
      PH_DN_REL: m[EV_BA_FALL] = 1'b1;
      default:   m[EV_AR_FALL] = 1'b1;
    endcase
    return m;
  endfunction

  function automatic phase_t step_after(phase_t p);
    case (p)
      PH_IDLE:   return PH_DN_REQ;
      PH_DN_REQ: return PH_DN_REL;
      PH_DN_REL: return PH_UP_ACK;
      default:   return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sync_out = pipe[LAST];
endmodule

// File: rtl/hs_edge_det.sv
module hs_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/hs_relay_fsm.sv
module hs_relay_fsm
  import hs_relay_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] events,
  output logic            dn_req,
  output logic            up_ack,
  output logic            proto_err
);
  phase_t          phase;
  logic [EV_W-1:0] want;
  logic            exp_hit;
  logic            unexp_hit;
  logic            advance;

  assign want      = awaited_edge(phase);
  assign exp_hit   = |(events & want);
  assign unexp_hit = |(events & ~want);
  assign advance   = exp_hit && !unexp_hit && !proto_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      proto_err <= 1'b0;
    end else if (!proto_err) begin
      if (unexp_hit)    proto_err <= 1'b1;
      else if (advance) phase     <= step_after(phase);
    end
  end

  assign dn_req = (phase == PH_DN_REQ);
  assign up_ack = (phase == PH_UP_ACK);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_req && up_ack));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_hold_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> ($stable(dn_req) && $stable(up_ack)));

  assert_br_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(events[EV_AR_RISE]));

  assert_br_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) |-> $past(events[EV_BA_RISE]));

  assert_aa_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> $past(events[EV_BA_FALL]));

  assert_aa_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ack) |-> $past(events[EV_AR_FALL]));

  assert_mixed_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_hit && unexp_hit && !proto_err) |=>
      (proto_err && $stable(dn_req) && $stable(up_ack)));
endmodule

// File: rtl/hs_relay_seq.sv
module hs_relay_seq
  import hs_relay_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  output logic up_ack,
  output logic dn_req,
  input  logic dn_ack,
  output logic proto_err
);
  localparam int N_IN = 2;
  localparam int I_AR = 0;
  localparam int I_BA = 1;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] sync_lvl;
  logic [N_IN-1:0] lvl_rise;
  logic [N_IN-1:0] lvl_fall;
  logic [EV_W-1:0] events;

  assign raw_in = {dn_ack, up_req};

  hs_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_lvl)
  );

  hs_edge_det #(.WIDTH(N_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_lvl), .rise(lvl_rise), .fall(lvl_fall)
  );

  always_comb begin
    events             = '0;
    events[EV_AR_RISE] = lvl_rise[I_AR];
    events[EV_AR_FALL] = lvl_fall[I_AR];
    events[EV_BA_RISE] = lvl_rise[I_BA];
    events[EV_BA_FALL] = lvl_fall[I_BA];
  end

  hs_relay_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .events(events),
    .dn_req(dn_req), .up_ack(up_ack), .proto_err(proto_err)
  );
endmodule

// File: tb/hs_relay_seq_test.sv
`timescale 1ns/1ps
module hs_relay_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dn_ack = 1'b0;
  logic up_ack, dn_req, proto_err;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  hs_relay_seq uut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .proto_err(proto_err)
  );

  // behavioural reference: delayed input copies plus a step counter
  int  m_step;
  bit  m_err;
  bit  m_ar[3];
  bit  m_ba[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_err = 0;
      foreach (m_ar[i]) begin m_ar[i] = 0; m_ba[i] = 0; end
    end else begin
      bit ar_r, ar_f, ba_r, ba_f, hit, stray;
      ar_r = m_ar[1] && !m_ar[2];
      ar_f = !m_ar[1] && m_ar[2];
      ba_r = m_ba[1] && !m_ba[2];
      ba_f = !m_ba[1] && m_ba[2];
      case (m_step)
        0: begin hit = ar_r; stray = ar_f || ba_r || ba_f; end
        1: begin hit = ba_r; stray = ar_r || ar_f || ba_f; end
        2: begin hit = ba_f; stray = ar_r || ar_f || ba_r; end
        default: begin hit = ar_f; stray = ar_r || ba_r || ba_f; end
      endcase
      if (!m_err) begin
        if (stray) m_err = 1;
        else if (hit) m_step = (m_step + 1) % 4;
      end
      m_ar[2] = m_ar[1]; m_ar[1] = m_ar[0]; m_ar[0] = up_req;
      m_ba[2] = m_ba[1]; m_ba[1] = m_ba[0]; m_ba[0] = dn_ack;
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R6 covers the overlap)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6", dn_req, (m_step == 1), "model dn_req");
      check("R6", up_ack, (m_step == 3), "model up_ack");
      check("R7", proto_err, m_err, "model proto_err");
      check("R6", dn_req && up_ack, 1'b0, "overlap");
    end
  end

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; up_req = 0; dn_ack = 0;
    wait_neg(2);
    rst_n = 1;
    wait_neg(1);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    do_reset();
    check("R1", dn_req, 0, "reset dn_req");
    check("R1", up_ack, 0, "reset up_ack");
    check("R1", proto_err, 0, "reset proto_err");

    // full nested handshake, twice
    for (int pass = 0; pass < 2; pass++) begin
      up_req = 1;
      wait_neg(2); check("R2", dn_req, 0, "dn_req before latency");
      wait_neg(1); check("R2", dn_req, 1, "dn_req rises");
      check("R2", up_ack, 0, "up_ack during downstream");
      wait_neg(2);
      dn_ack = 1;
      wait_neg(3); check("R3", dn_req, 0, "dn_req falls");
      check("R4", up_ack, 0, "up_ack waits for ba fall");
      wait_neg(1);
      dn_ack = 0;
      wait_neg(3); check("R4", up_ack, 1, "up_ack rises");
      up_req = 0;
      wait_neg(3); check("R5", up_ack, 0, "up_ack falls");
      check("R5", proto_err, 0, "clean cycle");
      wait_neg(2);
    end

    // stray downstream ack in idle
    dn_ack = 1;
    wait_neg(3); check("R7", proto_err, 1, "stray edge flags");
    up_req = 1;
    wait_neg(6); check("R7", dn_req, 0, "frozen after error");
    dn_ack = 0; up_req = 0;
    wait_neg(6); check("R7", proto_err, 1, "flag sticky");

    // stray edge while up_ack is high
    do_reset();
    up_req = 1; wait_neg(4); dn_ack = 1; wait_neg(4); dn_ack = 0; wait_neg(4);
    check("R4", up_ack, 1, "reached ack step");
    dn_ack = 1;
    wait_neg(3); check("R7", proto_err, 1, "stray in ack step");
    up_req = 0;
    wait_neg(5); check("R7", up_ack, 1, "up_ack held");

    // expected and stray edge in the same cycle
    do_reset();
    up_req = 1; wait_neg(4);
    check("R2", dn_req, 1, "setup for mixed");
    dn_ack = 1; up_req = 0;
    wait_neg(3); check("R8", proto_err, 1, "mixed edges flag");
    check("R8", dn_req, 1, "dn_req not released");
    wait_neg(4); check("R8", dn_req, 1, "dn_req still held");

    do_reset();
    check("R1", proto_err, 0, "reset clears flag");
    summary();
  end
endmodule